// File: doc/BRIEF.md
# Selectable-Rate Countdown Timer

This block is an 8-bit down-counter that produces a periodic timer event. Its count rate comes from one of four tick sources. The sources are built inside the block from a single reference enable that pulses at 4096 Hz. A divider chain derives a 64 Hz tick, a 1 Hz tick and a once-per-minute tick from that reference. A two-bit select input picks which of the four ticks moves the counter.

Software writes a start value. That value is copied into both the live count and a reload register. While running, the counter steps down once per selected tick. The step from one to zero raises a sticky timer flag. On the following tick the count is refilled from the reload register, and counting continues.

The interrupt output has two styles. In level style it follows the flag until software clears the flag. In pulse style it is a short strobe that ends at the next reference tick. An interrupt enable gates either style.

Top module: `cdtimer_top`

## Requirements
- R1: After reset, `count_o`, `flag_o` and `irq_o` are all 0, and the reload value is 0.
- R2: A cycle with `load_wr` high copies `load_val` into the count and the reload register. The new count is visible after that clock edge, whether `run_en` is high or low.
- R3: While `run_en` is low, the count does not change except through `load_wr`. The divider chain is held at the start of its period.
- R4: With `src_sel` = 0, the count steps down once on every clock edge at which `ref_tick` is high.
- R5: With `src_sel` = 1, 2 or 3, the count steps once every DIV_A, DIV_A*DIV_B or DIV_A*DIV_B*DIV_C reference ticks respectively. The first step comes one full period after the divider chain was released.
- R6: A step from 1 to 0 sets `flag_o` at that same edge. The next selected tick refills the count from the reload register, so one period spans N+1 ticks for a start value N.
- R7: `flag_o` stays set until a cycle with `flag_clr` high. If a new zero step and a clear fall in the same cycle, the flag stays set.
- R8: With `pulse_mode` = 0 and `irq_en` = 1, `irq_o` is high exactly while `flag_o` is high.
- R9: With `pulse_mode` = 1 and `irq_en` = 1, `irq_o` rises at the zero step and falls at the next edge with `ref_tick` high. `flag_o` behaves as in R6 and R7 in this mode too.
- R10: With `irq_en` = 0, `irq_o` stays low, but `flag_o` is still set by a zero step.
- R11: With a start value of 0, the count stays at 0 and `flag_o` is never set.
- R12: A `load_wr` while running restarts the divider chain. The first step after the write comes one full source period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle enable at the 4096 Hz reference rate |
| run_en | input | 1 | Countdown enable |
| src_sel | input | 2 | Tick source: 0 reference, 1 first divide, 2 second divide, 3 third divide |
| load_wr | input | 1 | Write strobe for the start value |
| load_val | input | CNT_W | Start value written by `load_wr` |
| irq_en | input | 1 | Interrupt enable |
| pulse_mode | input | 1 | 1 = pulse-style interrupt, 0 = level-style interrupt |
| flag_clr | input | 1 | Clears the timer flag |
| count_o | output | CNT_W | Current count |
| flag_o | output | 1 | Sticky timer flag |
| irq_o | output | 1 | Timer interrupt |

## Verification
The properties assume that `src_sel` and `pulse_mode` change only while `run_en` is low. They also assume that `ref_tick` is a synchronous enable and not a clock. The stimulus meets these assumptions: every scenario first stops the timer, then sets the configuration, and only then writes a start value together with `run_en`. The reference enable is either held high or toggled on alternate cycles at the falling edge, so every tick edge can be counted ahead of time. The bench shrinks the divide ratios through parameters so that the once-per-minute source completes in tens of cycles.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [1:0] {
    SRC_REF  = 2'd0,
    SRC_DIV1 = 2'd1,
    SRC_DIV2 = 2'd2,
    SRC_DIV3 = 2'd3
  } tick_src_e;

  localparam int NUM_STAGES = 3;
endpackage

// File: rtl/cdt_div_stage.sv
module cdt_div_stage #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic in_tick,
  output logic out_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase_q <= '0;
    else if (restart)
      phase_q <= '0;
    else if (in_tick)
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end

  assign out_tick = in_tick && (phase_q == LAST);
endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
  import cdt_pkg::*;
#(
  parameter int DIV_A = 64,
  parameter int DIV_B = 64,
  parameter int DIV_C = 60
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  restart,
  input  logic                  ref_tick,
  output logic [NUM_STAGES:0]   ticks
);
  localparam int DIVS [NUM_STAGES] = '{DIV_A, DIV_B, DIV_C};

  assign ticks[0] = ref_tick;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    cdt_div_stage #(.DIV(DIVS[g])) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .in_tick (ticks[g]),
      .out_tick(ticks[g+1])
    );
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             zero_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
    end else if (load) begin
      count_q  <= load_val;
      reload_q <= load_val;
    end else if (run && tick) begin
      count_q  <= (count_q == '0) ? reload_q : count_q - 1'b1;
    end
  end

  assign count    = count_q;
  assign zero_evt = run && tick && !load && (count_q == ONE);
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic zero_evt,
  input  logic flag_clr,
  input  logic irq_en,
  input  logic pulse_mode,
  output logic flag,
  output logic irq
);
  logic flag_q;
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (zero_evt)
      flag_q <= 1'b1;
    else if (flag_clr)
      flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pulse_q <= 1'b0;
    else if (zero_evt)
      pulse_q <= 1'b1;
    else if (ref_tick)
      pulse_q <= 1'b0;
  end

  assign flag = flag_q;
  assign irq  = irq_en && (pulse_mode ? pulse_q : flag_q);
endmodule

// File: rtl/cdtimer_top.sv
module cdtimer_top
  import cdt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_A = 64,
  parameter int DIV_B = 64,
  parameter int DIV_C = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             run_en,
  input  logic [1:0]       src_sel,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic             irq_en,
  input  logic             pulse_mode,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic [NUM_STAGES:0] ticks;
  logic                sel_tick;
  logic                zero_evt;
  logic                restart;
  tick_src_e           src;

  assign restart = load_wr || !run_en;
  assign src     = tick_src_e'(src_sel);

  cdt_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .ref_tick(ref_tick),
    .ticks   (ticks)
  );

  always_comb begin
    unique case (src)
      SRC_REF:  sel_tick = ticks[0];
      SRC_DIV1: sel_tick = ticks[1];
      SRC_DIV2: sel_tick = ticks[2];
      SRC_DIV3: sel_tick = ticks[3];
      default:  sel_tick = 1'b0;
    endcase
  end

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_en),
    .tick    (sel_tick),
    .load    (load_wr),
    .load_val(load_val),
    .count   (count_o),
    .zero_evt(zero_evt)
  );

  cdt_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .zero_evt  (zero_evt),
    .flag_clr  (flag_clr),
    .irq_en    (irq_en),
    .pulse_mode(pulse_mode),
    .flag      (flag_o),
    .irq       (irq_o)
  );
endmodule

// File: rtl/cdtimer_checks.sv
module cdtimer_checks #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             load_wr,
  input logic [CNT_W-1:0] load_val,
  input logic             irq_en,
  input logic             pulse_mode,
  input logic             flag_clr,
  input logic [CNT_W-1:0] count_o,
  input logic             flag_o,
  input logic             irq_o
);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> count_o == $past(load_val));

  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !load_wr) |=> $stable(count_o));

  assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_wr && $past(count_o) != '0 && count_o != $past(count_o) && !$past(load_wr))
      |-> count_o == $past(count_o) - 1'b1);

  assert_zero_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !load_wr && count_o == CNT_W'(1)) |=> (count_o == '0) |-> flag_o);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr) |=> flag_o);

  assert_level_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_o) && irq_en && !pulse_mode) |-> irq_o);

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_o);
endmodule

bind cdtimer_top cdtimer_checks #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_en    (run_en),
  .load_wr   (load_wr),
  .load_val  (load_val),
  .irq_en    (irq_en),
  .pulse_mode(pulse_mode),
  .flag_clr  (flag_clr),
  .count_o   (count_o),
  .flag_o    (flag_o),
  .irq_o     (irq_o)
);

// File: tb/cdtimer_top_test.sv
module cdtimer_top_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ref_tick = 1'b1;
  logic         run_en = 1'b0;
  logic [1:0]   src_sel = 2'd0;
  logic         load_wr = 1'b0;
  logic [W-1:0] load_val = '0;
  logic         irq_en = 1'b0;
  logic         pulse_mode = 1'b0;
  logic         flag_clr = 1'b0;
  logic [W-1:0] count_o;
  logic         flag_o;
  logic         irq_o;
  logic         gap = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cdtimer_top #(.CNT_W(W), .DIV_A(4), .DIV_B(4), .DIV_C(3)) uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .run_en(run_en),
    .src_sel(src_sel), .load_wr(load_wr), .load_val(load_val),
    .irq_en(irq_en), .pulse_mode(pulse_mode), .flag_clr(flag_clr),
    .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (gap) ref_tick = ~ref_tick;
    end
  endtask

  task automatic load(int v);
    load_val = W'(v);
    load_wr = 1'b1;
    step(1);
    load_wr = 1'b0;
  endtask

  task automatic prep(int src, bit ien, bit pmode);
    run_en = 1'b0;
    flag_clr = 1'b1;
    gap = 1'b0;
    ref_tick = 1'b1;
    step(1);
    flag_clr = 1'b0;
    src_sel = 2'(src);
    irq_en = ien;
    pulse_mode = pmode;
  endtask

  task automatic t_reset();
    check("R1 count", count_o, 0);
    check("R1 flag", flag_o, 0);
    check("R1 irq", irq_o, 0);
  endtask

  task automatic t_stopped();
    prep(0, 1'b0, 1'b0);
    load(5);
    check("R2 load while stopped", count_o, 5);
    step(10);
    check("R3 count held", count_o, 5);
    check("R3 no flag", flag_o, 0);
  endtask

  task automatic t_level();
    prep(0, 1'b1, 1'b0);
    run_en = 1'b1;
    load(3);
    check("R2 load", count_o, 3);
    step(2);
    check("R4 decrement", count_o, 1);
    check("R6 flag not yet", flag_o, 0);
    step(1);
    check("R6 zero", count_o, 0);
    check("R6 flag set", flag_o, 1);
    check("R8 level irq", irq_o, 1);
    step(1);
    check("R6 reload", count_o, 3);
    check("R7 flag held", flag_o, 1);
    step(1);
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    check("R7 cleared", flag_o, 0);
    check("R8 irq follows flag", irq_o, 0);
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    check("R7 set wins over clear", flag_o, 1);
  endtask

  task automatic t_noirq();
    prep(0, 1'b0, 1'b0);
    run_en = 1'b1;
    load(2);
    step(2);
    check("R10 flag still set", flag_o, 1);
    check("R10 irq masked", irq_o, 0);
  endtask

  task automatic t_pulse();
    prep(0, 1'b1, 1'b1);
    run_en = 1'b1;
    load(2);
    step(1);
    check("R9 before event", irq_o, 0);
    step(1);
    check("R9 pulse high", irq_o, 1);
    check("R9 flag set", flag_o, 1);
    step(1);
    check("R9 pulse ends", irq_o, 0);
    check("R9 flag kept", flag_o, 1);
  endtask

  task automatic t_pulse_gap();
    prep(0, 1'b1, 1'b1);
    run_en = 1'b1;
    ref_tick = 1'b0;
    gap = 1'b1;
    load(1);
    step(1);
    check("R9 gapped pulse rises", irq_o, 1);
    step(1);
    check("R9 pulse held without ref", irq_o, 1);
    step(1);
    check("R9 pulse ends on ref", irq_o, 0);
    gap = 1'b0;
    ref_tick = 1'b1;
  endtask

  task automatic t_src1();
    prep(1, 1'b0, 1'b0);
    run_en = 1'b1;
    load(2);
    step(3);
    check("R5 src1 no step yet", count_o, 2);
    step(1);
    check("R5 src1 first step", count_o, 1);
    step(3);
    check("R5 src1 flag early", flag_o, 0);
    step(1);
    check("R5 src1 flag", flag_o, 1);
  endtask

  task automatic t_src2();
    prep(2, 1'b0, 1'b0);
    run_en = 1'b1;
    load(1);
    step(15);
    check("R5 src2 flag early", flag_o, 0);
    step(1);
    check("R5 src2 flag", flag_o, 1);
  endtask

  task automatic t_src3();
    prep(3, 1'b0, 1'b0);
    run_en = 1'b1;
    load(1);
    step(47);
    check("R5 src3 count early", count_o, 1);
    check("R5 src3 flag early", flag_o, 0);
    step(1);
    check("R5 src3 flag", flag_o, 1);
  endtask

  task automatic t_restart();
    prep(1, 1'b0, 1'b0);
    run_en = 1'b1;
    load(2);
    step(6);
    check("R12 pre-write count", count_o, 1);
    load(2);
    check("R12 reload on write", count_o, 2);
    step(7);
    check("R12 flag early", flag_o, 0);
    check("R12 count", count_o, 1);
    step(1);
    check("R12 flag", flag_o, 1);
  endtask

  task automatic t_zero();
    prep(0, 1'b1, 1'b0);
    run_en = 1'b1;
    load(0);
    step(20);
    check("R11 count stays 0", count_o, 0);
    check("R11 no flag", flag_o, 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_stopped();
    t_level();
    t_noirq();
    t_pulse();
    t_pulse_gap();
    t_src1();
    t_src2();
    t_src3();
    t_restart();
    t_zero();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule